// File: doc/BRIEF.md
# Limit Comparator Interrupt with Consecutive-Fault Filter

This block watches a stream of conversion results, one per strobe. It decides when the light level has been outside a programmable window long enough to report it. Each strobed 16-bit result is compared against a high limit and a low limit. A separate run counter for each limit counts consecutive results that break that limit. When a run reaches the selected length (1, 2, 4 or 8), the matching flag is raised and the interrupt output goes active.

Two reporting styles are selectable. In latched style a raised flag stays up until a clear request arrives, which is normally a read of the configuration register. In transparent style each strobe rewrites both flags from that result's outcome, so no clearing is needed. The interrupt's active level is programmable. When no results arrive, as in shutdown, the flags and the interrupt keep their last state.

Top module: `limit_fault_irq`

## Requirements
- R1: After reset both flags are 0, both run counters are empty, and `intOut` shows the inactive level (1 when `intPolarity` is 0).
- R2: `faultCountSel` selects the run length needed to trip a flag: 2'b00 means 1, 2'b01 means 2, 2'b10 means 4 and 2'b11 means 8 consecutive strobed results.
- R3: A result breaks the high limit only if, as an unsigned 16-bit number, it is strictly greater than `highLimit`. A result equal to the limit does not count.
- R4: A result breaks the low limit only if, as an unsigned 16-bit number, it is strictly less than `lowLimit`. A result equal to the limit does not count.
- R5: The high and low run counters are independent. A strobed result that does not break a given limit empties that limit's counter.
- R6: With `latchMode`=1, a raised flag stays raised through later non-violating results until a clear request.
- R7: With `latchMode`=1, a `clearReq` drops both flags at the next clock edge. If a strobe in the same cycle trips a flag, that flag is raised instead: the set wins.
- R8: With `latchMode`=0, every strobe sets each flag to whether that result completed a run for its limit, and `clearReq` has no effect.
- R9: `intOut` is active whenever either flag is set. The active level is 0 when `intPolarity`=0 and 1 when `intPolarity`=1, and it follows `intPolarity` without a clock.
- R10: When no strobe and no effective clear occur, the flags and `intOut` hold indefinitely, even if the limits change.
- R11: A run counter saturates at 8. A run that keeps breaking the limit past its required length keeps tripping on every further result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resultValid | input | 1 | Strobe: `resultData` holds a new conversion result |
| resultData | input | 16 | Conversion result word (exponent and mantissa together) |
| highLimit | input | 16 | Upper comparison limit |
| lowLimit | input | 16 | Lower comparison limit |
| latchMode | input | 1 | 1 = latched window reporting, 0 = transparent |
| intPolarity | input | 1 | Interrupt active level |
| faultCountSel | input | 2 | Consecutive-fault run length select |
| clearReq | input | 1 | Clear request for latched flags |
| flagHigh | output | 1 | High-limit flag |
| flagLow | output | 1 | Low-limit flag |
| intOut | output | 1 | Interrupt line, level set by `intPolarity` |

## Verification
On every cycle the assertions check several properties. Flags only move on a strobe or an effective clear. A newly raised flag is always backed by a strict limit violation in the previous cycle. Counters never pass their saturation value. A clear without a strobe empties both flags. A transparent-mode strobe that does not violate a limit drops that flag. The interrupt level always matches the flag state and polarity. Only the bench's scenarios can show that the run length is exactly 1, 2, 4 or 8 for each select code. The same holds for the counters being independent and reset by a non-violating result, the set-wins rule on a simultaneous clear, and the stability of the flags across long idle stretches with the limits moved.

// File: rtl/limit_irq_pkg.sv
package limit_irq_pkg;
  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic evalStrobe;   // evaluate the present result
    logic clearStrobe;  // drop latched flags
    logic followMode;   // flags track each result (transparent style)
  } ctl_strobe_t;
endpackage

// File: rtl/limit_irq_ctl.sv
module limit_irq_ctl
  import limit_irq_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             resultValid,
  input  logic             clearReq,
  input  logic             latchMode,
  input  logic [SEL_W-1:0] faultCountSel,
  output ctl_strobe_t      strobes,
  output logic [CNT_W-1:0] needCount
);
  // Run length is a power of two: code n asks for 2**n consecutive faults.
  always_comb begin
    needCount = CNT_W'(1) << faultCountSel;
  end

  always_comb begin
    strobes.evalStrobe  = resultValid;
    strobes.clearStrobe = clearReq & latchMode;  // clearing only matters when latched
    strobes.followMode  = ~latchMode;
  end
endmodule

// File: rtl/limit_irq_dp.sv
module limit_irq_dp
  import limit_irq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int MAX_FAULTS = 8,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobes,
  input  logic [CNT_W-1:0]  needCount,
  input  logic [DATA_W-1:0] resultData,
  input  logic [DATA_W-1:0] highLimit,
  input  logic [DATA_W-1:0] lowLimit,
  output logic              flagHigh,
  output logic              flagLow
);
  localparam int NUM_CH = 2;  // channel 0 = high limit, channel 1 = low limit

  logic violate [NUM_CH];
  logic flagReg [NUM_CH];

  always_comb begin
    violate[0] = resultData > highLimit;
    violate[1] = resultData < lowLimit;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] runCnt;
    logic [CNT_W-1:0] runNext;
    logic             trip;

    always_comb begin
      if (!violate[ch])                          runNext = '0;
      else if (runCnt == CNT_W'(MAX_FAULTS))     runNext = runCnt;
      else                                       runNext = runCnt + CNT_W'(1);
      trip = violate[ch] && (runNext >= needCount);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCnt      <= '0;
        flagReg[ch] <= 1'b0;
      end else begin
        if (strobes.evalStrobe) runCnt <= runNext;
        if (strobes.evalStrobe && strobes.followMode) flagReg[ch] <= trip;
        else if (strobes.evalStrobe && trip)          flagReg[ch] <= 1'b1;
        else if (strobes.clearStrobe)                 flagReg[ch] <= 1'b0;
      end
    end

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
      runCnt <= CNT_W'(MAX_FAULTS));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.evalStrobe && !strobes.clearStrobe) |=> $stable(flagReg[ch]));

    assert_clear_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clearStrobe && !strobes.evalStrobe) |=> !flagReg[ch]);

    assert_follow_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.evalStrobe && strobes.followMode && !violate[ch]) |=> !flagReg[ch]);
  end

  assert_high_strict_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagReg[0]) |-> $past(resultData > highLimit));

  assert_low_strict_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagReg[1]) |-> $past(resultData < lowLimit));

  assign flagHigh = flagReg[0];
  assign flagLow  = flagReg[1];
endmodule

// File: rtl/limit_fault_irq.sv
module limit_fault_irq
  import limit_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] resultData,
  input  logic [DATA_W-1:0] highLimit,
  input  logic [DATA_W-1:0] lowLimit,
  input  logic              latchMode,
  input  logic              intPolarity,
  input  logic [SEL_W-1:0]  faultCountSel,
  input  logic              clearReq,
  output logic              flagHigh,
  output logic              flagLow,
  output logic              intOut
);
  localparam int MAX_FAULTS = 1 << ((1 << SEL_W) - 1);
  localparam int CNT_W      = $clog2(MAX_FAULTS + 1);

  ctl_strobe_t      strobes;
  logic [CNT_W-1:0] needCount;

  limit_irq_ctl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctl (
    .resultValid  (resultValid),
    .clearReq     (clearReq),
    .latchMode    (latchMode),
    .faultCountSel(faultCountSel),
    .strobes      (strobes),
    .needCount    (needCount)
  );

  limit_irq_dp #(.DATA_W(DATA_W), .MAX_FAULTS(MAX_FAULTS), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .needCount (needCount),
    .resultData(resultData),
    .highLimit (highLimit),
    .lowLimit  (lowLimit),
    .flagHigh  (flagHigh),
    .flagLow   (flagLow)
  );

  logic irqActive;
  assign irqActive = flagHigh | flagLow;
  assign intOut    = intPolarity ? irqActive : ~irqActive;

  assert_int_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagHigh || flagLow) |-> (intOut == intPolarity));

  assert_int_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!flagHigh && !flagLow) |-> (intOut != intPolarity));
endmodule

// File: tb/limit_fault_irq_test.sv
module limit_fault_irq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [15:0] resultData = '0;
  logic [15:0] highLimit = 16'h8000;
  logic [15:0] lowLimit = 16'h4000;
  logic        latchMode = 1'b1;
  logic        intPolarity = 1'b0;
  logic [1:0]  faultCountSel = 2'b00;
  logic        clearReq = 1'b0;
  logic        flagHigh, flagLow, intOut;

  int checks = 0;
  int fails = 0;
  int hiCnt = 0, loCnt = 0;
  logic expHigh = 1'b0, expLow = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  limit_fault_irq uut (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultData(resultData),
    .highLimit(highLimit), .lowLimit(lowLimit), .latchMode(latchMode),
    .intPolarity(intPolarity), .faultCountSel(faultCountSel), .clearReq(clearReq),
    .flagHigh(flagHigh), .flagLow(flagLow), .intOut(intOut)
  );

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic checkOne(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    logic act;
    act = expHigh | expLow;
    checkOne(tag, "flagHigh", flagHigh, expHigh);
    checkOne(tag, "flagLow", flagLow, expLow);
    checkOne(tag, "intOut", intOut, intPolarity ? act : ~act);
  endtask

  // Called at a negedge; leaves at the following negedge.
  task automatic doReset();
    rstN = 1'b0;
    resultValid = 1'b0;
    clearReq = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    hiCnt = 0; loCnt = 0; expHigh = 1'b0; expLow = 1'b0;
  endtask

  // Expected behaviour from the requirements.
  task automatic model(input logic v, input logic [15:0] d, input logic c);
    int need;
    logic hv, lv, ht, lt;
    need = 1 << faultCountSel;                       // R2 encoding
    if (v) begin
      hv = d > highLimit;                            // R3 strict
      lv = d < lowLimit;                             // R4 strict
      hiCnt = hv ? ((hiCnt < 8) ? hiCnt + 1 : 8) : 0; // R5, R11
      loCnt = lv ? ((loCnt < 8) ? loCnt + 1 : 8) : 0;
      ht = hv && (hiCnt >= need);
      lt = lv && (loCnt >= need);
      if (!latchMode) begin                          // R8
        expHigh = ht; expLow = lt;
      end else begin                                 // R6, R7
        expHigh = ht | (expHigh & ~c);
        expLow  = lt | (expLow & ~c);
      end
    end else if (latchMode && c) begin
      expHigh = 1'b0; expLow = 1'b0;
    end
  endtask

  task automatic step(input logic v, input logic [15:0] d, input logic c, input string tag);
    resultValid = v; resultData = d; clearReq = c;
    @(posedge clk);
    #1;
    resultValid = 1'b0; clearReq = 1'b0;
    model(v, d, c);
    checkAll(tag);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(negedge clk);
    doReset();
    checkAll("R1");
    checkOne("R1", "intOut_pol0", intOut, 1'b1);

    // R2: run length per select code, both limits, latched
    for (int s = 0; s < 4; s++) begin
      faultCountSel = 2'(s);
      latchMode = 1'b1;
      doReset();
      for (int n = 1; n <= 9; n++) step(1'b1, 16'h8001, 1'b0, "R2");
      step(1'b0, 16'h0, 1'b1, "R7");
      for (int n = 1; n <= 9; n++) step(1'b1, 16'h3FFF, 1'b0, "R2");
    end

    // R3 / R4: equality does not count, one past does
    faultCountSel = 2'b00;
    doReset();
    step(1'b1, 16'h8000, 1'b0, "R3");
    step(1'b1, 16'h4000, 1'b0, "R4");
    step(1'b1, 16'hFFFF, 1'b0, "R3");
    step(1'b1, 16'h0000, 1'b0, "R4");
    checkOne("R3", "flagHigh_set", flagHigh, 1'b1);
    checkOne("R4", "flagLow_set", flagLow, 1'b1);

    // R5: independent counters, reset by a non-violating result
    faultCountSel = 2'b01;
    doReset();
    step(1'b1, 16'h9000, 1'b0, "R5");
    step(1'b1, 16'h1000, 1'b0, "R5");
    step(1'b1, 16'h9000, 1'b0, "R5");
    step(1'b1, 16'h6000, 1'b0, "R5");
    step(1'b1, 16'h9000, 1'b0, "R5");
    checkOne("R5", "flagHigh_none", flagHigh, 1'b0);
    step(1'b1, 16'h9000, 1'b0, "R5");
    checkOne("R5", "flagHigh_two", flagHigh, 1'b1);

    // R6: latched flag survives in-window results; R7 clear and set-wins
    for (int k = 0; k < 5; k++) step(1'b1, 16'h6000, 1'b0, "R6");
    checkOne("R6", "flagHigh_held", flagHigh, 1'b1);
    step(1'b0, 16'h0, 1'b1, "R7");
    checkOne("R7", "flagHigh_cleared", flagHigh, 1'b0);
    step(1'b1, 16'h9000, 1'b0, "R7");
    step(1'b1, 16'h9000, 1'b1, "R7");
    checkOne("R7", "set_wins", flagHigh, 1'b1);

    // R8: transparent style, clear ignored
    latchMode = 1'b0;
    faultCountSel = 2'b00;
    doReset();
    step(1'b1, 16'h9000, 1'b0, "R8");
    step(1'b0, 16'h0, 1'b1, "R8");
    checkOne("R8", "clear_ignored", flagHigh, 1'b1);
    step(1'b1, 16'h6000, 1'b0, "R8");
    step(1'b1, 16'h1000, 1'b0, "R8");
    step(1'b1, 16'h9000, 1'b0, "R8");

    // R9: polarity without a clock edge
    intPolarity = 1'b1; #1; checkAll("R9");
    checkOne("R9", "active_high", intOut, 1'b1);
    intPolarity = 1'b0; #1; checkAll("R9");
    checkOne("R9", "active_low", intOut, 1'b0);
    @(negedge clk);

    // R10: idle hold with limits moved
    highLimit = 16'hFFFF; lowLimit = 16'h0000;
    repeat (50) @(negedge clk);
    checkAll("R10");
    highLimit = 16'h8000; lowLimit = 16'h4000;

    // R11: saturation keeps tripping, transparent, run of 8
    faultCountSel = 2'b11;
    doReset();
    for (int n = 1; n <= 20; n++) step(1'b1, 16'hC000, 1'b0, "R11");
    checkOne("R11", "still_set", flagHigh, 1'b1);

    // Mixed sweep over all modes and select codes
    highLimit = 16'hA000; lowLimit = 16'h6000;
    for (int lm = 0; lm < 2; lm++) begin
      for (int s = 0; s < 4; s++) begin
        latchMode = lm[0]; faultCountSel = 2'(s); intPolarity = s[0];
        doReset();
        for (int k = 0; k < 60; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          step(lfsr[3:0] != 4'h0, (lfsr[5] ? lfsr : {lfsr[15:14], 14'h0}),
               lfsr[9:7] == 3'b000, lm == 1 ? "R6" : "R8");
        end
      end
    end

    finishRun();
  end
endmodule